// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to an I2C bus without ever driving it. Its inputs are SCL and SDA levels that have already been synchronised to the system clock. Every clock cycle counts as one sample, and the sampling clock should run far faster than SCL: buses at 3.4 Mbit/s must still be resolved, so each SCL phase has to last several samples. The monitor detects START, repeated START and STOP conditions. On each SCL rising edge it gathers one bit, and it groups the bits into nine-bit frames, each made of a byte and an acknowledge bit.

Each bus event becomes a record on a valid/ready stream. A record carries a type code, a byte value and two timestamps, the first and the last sample of the event. The timestamps come from a free-running sample counter. A byte frame produces two records: the byte record, which is classified as address or data and as read or write, and then a separate acknowledge record. Two records can wait in the block. A record that finds no free slot is dropped and a sticky overflow flag is raised.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, ev_valid and ev_ovf are 0 and the sample counter reads 0 on the first sample. That first sample only records the line levels, so the monitor evaluates no edge on it, whatever the levels are.
- R2: A START is detected when SDA changes from 1 to 0 while SCL is 1 on the current sample, with no transfer open. It is reported as type 1 with byte 0, and both timestamps equal that sample. A START takes priority over an SCL rise on the same sample.
- R3: The same SDA fall detected while a transfer is open is a repeated START, type 2. It discards any partly collected frame.
- R4: A STOP is detected when SDA changes from 0 to 1 while SCL is high on both the previous and the current sample. It is reported as type 9 with equal timestamps. It closes the transfer, after which SCL edges produce no records until the next START.
- R5: While a transfer is open, bits are taken on SCL rising edges, most significant bit first. The ninth bit completes a frame and is the acknowledge bit. SCL edges while no transfer is open produce no records.
- R6: The first frame after a START or repeated START is the address. Its byte bit 0 is the direction: 0 gives type 3 (address write) and 1 gives type 4 (address read). The record's byte field holds the byte with bit 0 cleared.
- R7: Later frames are data frames, and the record carries the full byte. Their type is 5 (data write) or 6 (data read), following the direction bit of the last address.
- R8: Every byte record is followed by an acknowledge record. It has type 7 when the ninth bit is 0 and type 8 when it is 1, and both of its timestamps equal the sample of the ninth rise.
- R9: A byte record's start timestamp is the sample of its first SCL rise, and its end timestamp is one less than the sample of its ninth rise.
- R10: Records leave in the order they were produced. A record stays on the outputs, unchanged, until ev_ready accepts it, and up to two records can be pending.
- R11: A record produced when both slots are full is lost, and ev_ovf then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| ev_ready | input | 1 | Downstream accepts the current record |
| ev_valid | output | 1 | A record is present on the outputs |
| ev_type | output | 4 | Event type code (1 to 9) |
| ev_byte | output | 8 | Byte value, 0 for condition and acknowledge records |
| ev_start | output | TS_W | Sample count at which the event begins |
| ev_end | output | TS_W | Sample count at which the event ends |
| ev_ovf | output | 1 | Sticky flag: a record has been dropped |

## Verification
The checker watches several properties on every cycle. A stalled record must stay valid and unchanged. The overflow flag must never clear. A record's start may not come after its end, and point events must have equal timestamps. Address records must carry bit 0 cleared, and type codes must stay in range. Other properties can only be shown by the bench's scenarios, because they depend on the bus history: how a byte is classified by its position after a START, whether START or repeated START is chosen, the exact sample numbers, a partial frame discarded by a START, bits ignored while idle, the first sample after reset, and which record is lost when the stream stalls.

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  input  logic            ev_ready,
  output logic            ev_valid,
  output logic [3:0]      ev_type,
  output logic [7:0]      ev_byte,
  output logic [TS_W-1:0] ev_start,
  output logic [TS_W-1:0] ev_end,
  output logic            ev_ovf
);

  localparam int REC_W = 12 + 2 * TS_W;

  localparam logic [3:0] T_START  = 4'd1;
  localparam logic [3:0] T_RSTART = 4'd2;
  localparam logic [3:0] T_ADR_WR = 4'd3;
  localparam logic [3:0] T_ADR_RD = 4'd4;
  localparam logic [3:0] T_DAT_WR = 4'd5;
  localparam logic [3:0] T_DAT_RD = 4'd6;
  localparam logic [3:0] T_ACK    = 4'd7;
  localparam logic [3:0] T_NACK   = 4'd8;
  localparam logic [3:0] T_STOP   = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} phase_t;

  phase_t          phase;
  logic            primed, scl_q, sda_q, dir_rd;
  logic [3:0]      bcnt;
  logic [7:0]      shreg;
  logic [TS_W-1:0] ts, first_ts;

  logic [REC_W-1:0] q0, q1, n0, n1, rec_a, rec_b;
  logic [1:0]       cnt, nc;
  logic             va, vb, drop, pop;
  logic [3:0]       byte_type;
  logic [7:0]       byte_val;

  wire sda_fall   = primed & sda_q & ~sda_in & scl_in;
  wire sda_rise   = primed & scl_q & scl_in & ~sda_q & sda_in;
  wire scl_rise   = primed & ~scl_q & scl_in & ~sda_fall;
  wire capt       = scl_rise & (phase != S_IDLE);
  wire frame_done = capt & (bcnt == 4'd8);

  always_comb begin
    if (phase == S_ADDR) begin
      byte_type = shreg[0] ? T_ADR_RD : T_ADR_WR;
      byte_val  = {shreg[7:1], 1'b0};
    end else begin
      byte_type = dir_rd ? T_DAT_RD : T_DAT_WR;
      byte_val  = shreg;
    end
  end

  always_comb begin
    va    = 1'b0;
    vb    = 1'b0;
    rec_a = '0;
    rec_b = '0;
    if (sda_fall) begin
      va    = 1'b1;
      rec_a = {(phase == S_IDLE) ? T_START : T_RSTART, 8'h00, ts, ts};
    end else if (sda_rise) begin
      va    = 1'b1;
      rec_a = {T_STOP, 8'h00, ts, ts};
    end else if (frame_done) begin
      va    = 1'b1;
      vb    = 1'b1;
      rec_a = {byte_type, byte_val, first_ts, ts - TS_W'(1)};
      rec_b = {sda_in ? T_NACK : T_ACK, 8'h00, ts, ts};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed   <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      ts       <= '0;
      phase    <= S_IDLE;
      dir_rd   <= 1'b0;
      bcnt     <= '0;
      shreg    <= '0;
      first_ts <= '0;
    end else begin
      primed <= 1'b1;
      scl_q  <= scl_in;
      sda_q  <= sda_in;
      ts     <= ts + TS_W'(1);
      if (sda_fall) begin
        phase <= S_ADDR;
        bcnt  <= '0;
        shreg <= '0;
      end else if (sda_rise) begin
        phase  <= S_IDLE;
        dir_rd <= 1'b0;
        bcnt   <= '0;
      end else if (capt) begin
        if (bcnt == 4'd0) first_ts <= ts;
        if (bcnt == 4'd8) begin
          bcnt <= '0;
          if (phase == S_ADDR) begin
            phase  <= S_DATA;
            dir_rd <= shreg[0];
          end
        end else begin
          bcnt  <= bcnt + 4'd1;
          shreg <= {shreg[6:0], sda_in};
        end
      end
    end
  end

  assign pop = ev_valid & ev_ready;

  always_comb begin
    n0   = q0;
    n1   = q1;
    nc   = cnt;
    drop = 1'b0;
    if (pop) begin
      n0 = q1;
      nc = cnt - 2'd1;
    end
    if (va) begin
      if (nc == 2'd0) n0 = rec_a;
      else if (nc == 2'd1) n1 = rec_a;
      if (nc == 2'd2) drop = 1'b1;
      else nc = nc + 2'd1;
    end
    if (vb) begin
      if (nc == 2'd0) n0 = rec_b;
      else if (nc == 2'd1) n1 = rec_b;
      if (nc == 2'd2) drop = 1'b1;
      else nc = nc + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q0     <= '0;
      q1     <= '0;
      cnt    <= '0;
      ev_ovf <= 1'b0;
    end else begin
      q0  <= n0;
      q1  <= n1;
      cnt <= nc;
      if (drop) ev_ovf <= 1'b1;
    end
  end

  assign ev_valid = (cnt != 2'd0);
  assign {ev_type, ev_byte, ev_start, ev_end} = q0;

endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_ready,
  input logic            ev_valid,
  input logic [3:0]      ev_type,
  input logic [7:0]      ev_byte,
  input logic [TS_W-1:0] ev_start,
  input logic [TS_W-1:0] ev_end,
  input logic            ev_ovf
);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_type) && $stable(ev_byte)
                              && $stable(ev_start) && $stable(ev_end));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> ev_ovf);

  // R9
  range_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_start <= ev_end);

  // R8
  point_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && (ev_type == 4'd1 || ev_type == 4'd2 || ev_type == 4'd7 ||
                 ev_type == 4'd8 || ev_type == 4'd9) |-> ev_start == ev_end);

  // R6
  addr_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && (ev_type == 4'd3 || ev_type == 4'd4) |-> ev_byte[0] == 1'b0);

  // R5
  type_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_type >= 4'd1 && ev_type <= 4'd9);

endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready), .ev_valid(ev_valid),
  .ev_type(ev_type), .ev_byte(ev_byte), .ev_start(ev_start),
  .ev_end(ev_end), .ev_ovf(ev_ovf)
);

// File: tb/i2c_bus_monitor_bench.sv
module i2c_bus_monitor_bench;
  localparam int TS_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, ev_ready = 1'b1;
  logic ev_valid, ev_ovf;
  logic [3:0] ev_type;
  logic [7:0] ev_byte;
  logic [TS_W-1:0] ev_start, ev_end;

  always #4 clk = ~clk;

  i2c_bus_monitor #(.TS_W(TS_W)) u_i2c_bus_monitor (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .ev_ready(ev_ready), .ev_valid(ev_valid), .ev_type(ev_type),
    .ev_byte(ev_byte), .ev_start(ev_start), .ev_end(ev_end), .ev_ovf(ev_ovf)
  );

  int checks = 0, fails = 0, smp = 0;
  int gn = 0, en = 0;
  int got_t[64], got_b[64], got_s[64], got_e[64];
  int exp_t[64], exp_b[64], exp_s[64], exp_e[64];
  bit m_open = 0, m_addr = 0, m_rd = 0;

  // {start_before, byte, ack_bit, stop_after}
  localparam logic [10:0] VEC [6] = '{
    {1'b1, 8'hA0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b0},
    {1'b0, 8'h5A, 1'b1, 1'b0},
    {1'b1, 8'hA1, 1'b0, 1'b0},
    {1'b0, 8'hFE, 1'b1, 1'b1},
    {1'b1, 8'h3C, 1'b1, 1'b1}
  };

  always @(negedge clk)
    if (rst_n && ev_valid && ev_ready && gn < 64) begin
      got_t[gn] = int'(ev_type);
      got_b[gn] = int'(ev_byte);
      got_s[gn] = int'(ev_start);
      got_e[gn] = int'(ev_end);
      gn++;
    end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int t);
    case (t)
      1: return "R2";
      2: return "R3";
      3, 4: return "R6";
      5, 6: return "R7";
      7, 8: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic push_exp(input int t, input int b, input int s, input int e);
    exp_t[en] = t; exp_b[en] = b; exp_s[en] = s; exp_e[en] = e;
    en++;
  endtask

  task automatic drive(input logic c, input logic d);
    scl_in = c;
    sda_in = d;
    @(posedge clk);
    #2;
    smp++;
  endtask

  task automatic send_bit(input logic v, output int rise);
    drive(1'b0, sda_in);
    drive(1'b0, v);
    rise = smp;
    drive(1'b1, v);
    drive(1'b1, v);
  endtask

  task automatic do_start();
    int idx;
    drive(1'b0, sda_in);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    idx = smp;
    drive(1'b1, 1'b0);
    push_exp(m_open ? 2 : 1, 0, idx, idx);
    m_open = 1;
    m_addr = 1;
  endtask

  task automatic do_stop();
    int idx;
    drive(1'b0, sda_in);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    idx = smp;
    drive(1'b1, 1'b1);
    push_exp(9, 0, idx, idx);
    m_open = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack);
    int f, r, n;
    f = 0;
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i], r);
      if (i == 7) f = r;
    end
    send_bit(ack, n);
    if (m_open) begin
      if (m_addr) begin
        push_exp(b[0] ? 4 : 3, int'(b & 8'hFE), f, n - 1);
        m_rd = b[0];
        m_addr = 0;
      end else begin
        push_exp(m_rd ? 6 : 5, int'(b), f, n - 1);
      end
      push_exp(ack ? 8 : 7, 0, n, n);
    end
  endtask

  task automatic compare_all(input string tag);
    repeat (4) drive(scl_in, sda_in);
    check(gn == en, tag, "record count", gn, en);
    for (int i = 0; i < en && i < gn; i++) begin
      check(got_t[i] == exp_t[i], tag_of(exp_t[i]), "type", got_t[i], exp_t[i]);
      check(got_b[i] == exp_b[i], tag_of(exp_t[i]), "byte", got_b[i], exp_b[i]);
      check(got_s[i] == exp_s[i], (exp_t[i] >= 3 && exp_t[i] <= 6) ? "R9" : tag_of(exp_t[i]),
            "start sample", got_s[i], exp_s[i]);
      check(got_e[i] == exp_e[i], (exp_t[i] >= 3 && exp_t[i] <= 6) ? "R9" : tag_of(exp_t[i]),
            "end sample", got_e[i], exp_e[i]);
    end
    gn = 0;
    en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1;
    smp = 0;
    gn = 0;
    en = 0;
    m_open = 0;
    m_addr = 0;
    m_rd = 0;
  endtask

  initial begin
    int dummy;
    // R1: the first sample after reset has SCL high and SDA low; it must not count as a START
    scl_in = 1'b1;
    sda_in = 1'b0;
    do_reset();
    check(ev_valid == 1'b0, "R1", "valid after reset", ev_valid, 0);
    check(ev_ovf == 1'b0, "R1", "ovf after reset", ev_ovf, 0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    compare_all("R1");

    // R5: a byte clocked while idle produces nothing
    send_byte(8'hA5, 1'b0);
    compare_all("R5");

    // vector table: R2 R3 R4 R6 R7 R8 R9
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][10]) do_start();
      send_byte(VEC[v][9:2], VEC[v][1]);
      if (VEC[v][0]) do_stop();
    end
    compare_all("R10");

    // R3: a repeated START in the middle of a byte discards the partial frame
    do_start();
    send_bit(1'b1, dummy);
    send_bit(1'b0, dummy);
    send_bit(1'b1, dummy);
    send_bit(1'b1, dummy);
    do_start();
    send_byte(8'h92, 1'b0);
    send_byte(8'h44, 1'b1);
    do_stop();
    // R4: after the STOP the bus is idle, so this byte yields no records
    send_byte(8'h77, 1'b0);
    compare_all("R3");

    // R11: with the stream stalled, the acknowledge record finds no free slot
    ev_ready = 1'b0;
    do_start();
    send_byte(8'hA0, 1'b0);
    en--;
    check(ev_ovf == 1'b1, "R11", "ovf after drop", ev_ovf, 1);
    check(ev_valid == 1'b1 && ev_type == 4'd1, "R10", "head held while stalled",
          ev_type, 1);
    ev_ready = 1'b1;
    do_stop();
    compare_all("R11");
    check(ev_ovf == 1'b1, "R11", "ovf sticky", ev_ovf, 1);

    // R1: a second reset clears the flag
    scl_in = 1'b1;
    sda_in = 1'b1;
    do_reset();
    check(ev_ovf == 1'b0, "R1", "ovf cleared by reset", ev_ovf, 0);
    check(ev_valid == 1'b0, "R1", "valid cleared by reset", ev_valid, 0);
    // R2: the first START after reset carries its own sample number
    drive(1'b1, 1'b1);
    do_start();
    do_stop();
    compare_all("R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule